// File: doc/BRIEF.md
# Smart Card Serial Status Flags

This block holds the eight status flags of a half-duplex smart card serial channel. The transmit and receive shifters report events to it as single-cycle strobes: a transmit byte moved into the shifter, a received character finished, the card pulling the line low during the guard window, and a character fully sent. It also receives the transmit-enable and guard-mode controls and a tick at every half elementary time unit (etu). It presents the flags as one byte to the processor, and DMA service strobes clear the data-ready flags.

The error and data flags clear only through a handshake. A processor read must first return the flag as 1. A later write of 0 to that bit then clears it. Writing 1, or writing 0 without that read, changes nothing. The transmit-end flag rises after a delay that depends on the guard mode, counted in half-etu ticks after a character has been sent. It rises only if the transmit buffer is empty and no error signal has been seen.

Top module: `sc_status_flags`

## Requirements
- R1: After reset the status byte is 8'h84. Bit positions from bit 7 to bit 0 are: transmit-empty, receive-full, overrun, error-signal, parity-error, transmit-end, received multiprocessor bit, multiprocessor transfer bit.
- R2: A flag in bits 7..3 clears when a write carries 0 in its bit and an earlier read (since the last write) returned that flag as 1. The write also cancels every pending read.
- R3: Writing 1 to a bit in 7..3 has no effect. Writing 0 with no qualifying read since the last write also has no effect.
- R4: Bits 2 and 1 ignore writes. Bit 0 takes the value of `wr_data[0]` on every write.
- R5: Transmit-empty is 1 in every cycle after one with `tx_en` low, and is set by `tx_load`. It is cleared by the handshake or by `dma_wr`. A set and a clear in the same cycle leave it set.
- R6: A received character with correct parity sets receive-full. `dma_rd` or the handshake clears it.
- R7: Any `rx_end` while receive-full is 1 sets overrun. Receive-full stays 1.
- R8: At `rx_end` the parity is checked. `par_odd`=0 requires an even count of ones in `rx_data` plus `rx_par`, and `par_odd`=1 requires an odd count. A mismatch sets parity-error and leaves receive-full unchanged.
- R9: `err_low` sets error-signal. Only the handshake clears it, and `tx_en` has no effect on it.
- R10: After `char_sent`, transmit-end sets on the 5th `half_tick` (guard mode 0) or the 2nd (guard mode 1), counting only ticks. It sets only if transmit-empty is 1 and error-signal is 0 at that tick.
- R11: Transmit-end sets in the cycle after `tx_en` is low while error-signal is 0. It clears together with transmit-empty, by the handshake on bit 7 or by `dma_wr`.
- R12: At every `rx_end` the received multiprocessor bit takes the value of `rx_mpb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmitter enable |
| guard_mode | input | 1 | Selects the short transmit-end delay |
| half_tick | input | 1 | Strobe at each half etu |
| tx_load | input | 1 | Holding byte moved into the transmit shifter |
| char_sent | input | 1 | Last bit of a character sent |
| rx_end | input | 1 | Reception of a character finished |
| rx_data | input | 8 | Received data byte |
| rx_par | input | 1 | Received parity bit |
| rx_mpb | input | 1 | Received multiprocessor bit |
| par_odd | input | 1 | 1 selects odd parity |
| err_low | input | 1 | Error signal sampled low |
| rd_en | input | 1 | Processor read of the status byte |
| wr_en | input | 1 | Processor write of the status byte |
| wr_data | input | 8 | Processor write data |
| dma_wr | input | 1 | DMA wrote the transmit holding byte |
| dma_rd | input | 1 | DMA read the receive byte |
| status | output | 8 | Status byte |
| tx_end | output | 1 | Transmit-end indication |

## Verification
The assertions check on every cycle the rules that hold at any instant: transmit-empty is forced while the transmitter is disabled, transmit-end is forced while disabled with no error signal, and overrun follows a reception that lands on a full buffer. They also check that error-signal and parity-error survive any write that cannot clear them, and that a pending error signal blocks transmit-end. The bench scenarios cover the rest. These are the exact tick count of the transmit-end delay in both guard modes, and parity across every data byte, parity bit and parity sense. They also cover the handshake applied to each flag with and without the qualifying read, and the read-only and read/write low bits.

// File: rtl/sc_status_flags.sv
module sc_status_flags #(
  parameter int GM0_HALVES = 5,
  parameter int GM1_HALVES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_en,
  input  logic       guard_mode,
  input  logic       half_tick,
  input  logic       tx_load,
  input  logic       char_sent,
  input  logic       rx_end,
  input  logic [7:0] rx_data,
  input  logic       rx_par,
  input  logic       rx_mpb,
  input  logic       par_odd,
  input  logic       err_low,
  input  logic       rd_en,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       dma_wr,
  input  logic       dma_rd,
  output logic [7:0] status,
  output logic       tx_end
);
  localparam int MAXH = (GM0_HALVES > GM1_HALVES) ? GM0_HALVES : GM1_HALVES;
  localparam int CW   = $clog2(MAXH + 1);

  logic tdre, rdrf, orer, ers, per, tend, mpb, mpbt;
  logic [4:0] armed;
  logic [CW-1:0] cnt;
  logic run;

  assign status = {tdre, rdrf, orer, ers, per, tend, mpb, mpbt};
  assign tx_end = tend;

  wire [4:0] clr     = wr_en ? (armed & ~wr_data[7:3]) : 5'b0;
  wire       rx_bad  = rx_end && ((^{rx_data, rx_par}) != par_odd);
  wire       rx_good = rx_end && !rx_bad;
  wire       tx_clr  = clr[4] | dma_wr;
  wire       fire    = run && half_tick && (cnt == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tdre <= 1'b1; rdrf <= 1'b0; orer <= 1'b0; ers <= 1'b0;
      per  <= 1'b0; tend <= 1'b1; mpb  <= 1'b0; mpbt <= 1'b0;
      armed <= '0;
    end else begin
      if (!tx_en || tx_load) tdre <= 1'b1;
      else if (tx_clr)       tdre <= 1'b0;

      if (rx_good)                rdrf <= 1'b1;
      else if (clr[3] || dma_rd)  rdrf <= 1'b0;

      if (rx_end && rdrf) orer <= 1'b1;
      else if (clr[2])    orer <= 1'b0;

      if (err_low)     ers <= 1'b1;
      else if (clr[1]) ers <= 1'b0;

      if (rx_bad)      per <= 1'b1;
      else if (clr[0]) per <= 1'b0;

      if ((!tx_en && !ers) || (fire && tdre && !ers)) tend <= 1'b1;
      else if (tx_clr)                                tend <= 1'b0;

      if (rx_end) mpb  <= rx_mpb;
      if (wr_en)  mpbt <= wr_data[0];

      if (wr_en)      armed <= '0;
      else if (rd_en) armed <= armed | status[7:3];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (char_sent) begin
      cnt <= guard_mode ? CW'(GM1_HALVES) : CW'(GM0_HALVES);
      run <= 1'b1;
    end else if (run && half_tick) begin
      cnt <= cnt - CW'(1);
      if (cnt == CW'(1)) run <= 1'b0;
    end
  end

  // R5
  tdre_te_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> tdre);
  // R11
  tend_te_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !ers) |=> tend);
  // R7
  orer_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_end && rdrf) |=> (orer && rdrf));
  // R9
  ers_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ers && !(wr_en && armed[1] && !wr_data[4])) |=> ers);
  // R3
  per_write_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (per && wr_en && wr_data[3]) |=> per);
  // R10
  tend_ers_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tend && ers) |=> !tend);
endmodule

// File: tb/sc_status_flags_tb.sv
module sc_status_flags_tb_top;
  logic clk = 0, rst_n = 0;
  logic tx_en = 0, guard_mode = 0, half_tick = 0, tx_load = 0, char_sent = 0;
  logic rx_end = 0, rx_par = 0, rx_mpb = 0, par_odd = 0, err_low = 0;
  logic rd_en = 0, wr_en = 0, dma_wr = 0, dma_rd = 0;
  logic [7:0] rx_data = 0, wr_data = 0, status, rv;
  logic tx_end;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  sc_status_flags dut_i (.*);

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask

  task automatic do_reset();
    rst_n = 0; tx_en = 0; repeat (3) cyc(); rst_n = 1; cyc();
  endtask

  task automatic rd(output logic [7:0] v);
    rd_en = 1; v = status; cyc(); rd_en = 0;
  endtask

  task automatic wr(logic [7:0] d);
    wr_en = 1; wr_data = d; cyc(); wr_en = 0;
  endtask

  task automatic rx(logic [7:0] d, logic p, logic m);
    rx_end = 1; rx_data = d; rx_par = p; rx_mpb = m; cyc(); rx_end = 0;
  endtask

  task automatic tick_n(int n);
    for (int k = 0; k < n; k++) begin half_tick = 1; cyc(); half_tick = 0; cyc(); end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 reset status", status, 8'h84);
    chk("R1 reset tx_end", {7'b0, tx_end}, 8'h01);
    tx_en = 1; cyc();

    // R8 / R6: every byte, parity bit and parity sense
    for (int o = 0; o < 2; o++)
      for (int d = 0; d < 256; d++)
        for (int p = 0; p < 2; p++) begin
          logic bad;
          par_odd = o[0];
          bad = (($countones(d[7:0]) + p) % 2) != o;
          rx(d[7:0], p[0], 1'b0);
          chk("R8 parity flag", {7'b0, status[3]}, {7'b0, bad});
          chk("R6 receive-full", {7'b0, status[6]}, {7'b0, !bad});
          dma_rd = 1; cyc(); dma_rd = 0;
          if (bad) begin rd(rv); wr(8'hF6); end
          chk("R6 cleared", status[6:3], 4'h0);
        end
    par_odd = 0;

    // R2 / R3: handshake for each of bits 7..3
    for (int i = 3; i < 8; i++) begin
      logic [7:0] ex;
      do_reset(); tx_en = 1; cyc();
      rx(8'h00, 0, 0);
      rx(8'h00, 0, 0);
      chk("R7 overrun with full buffer", status[6:5], 2'b11);
      err_low = 1; cyc(); err_low = 0;
      rx(8'h00, 1, 0);
      chk("R3 all flags set", status, 8'hFC);
      wr(8'h00);
      chk("R3 write 0 without read", status, 8'hFC);
      rd(rv);
      chk("R2 read value", rv, 8'hFC);
      wr(8'hFF);
      chk("R3 write 1 after read", status, 8'hFD);
      wr(~(8'h01 << i) & 8'hFE);
      chk("R3 write 0 after cancelled read", status, 8'hFC);
      rd(rv);
      wr(~(8'h01 << i) & 8'hFE);
      ex = 8'hFC & ~(8'h01 << i);
      if (i == 7) ex = ex & 8'hFB;
      chk("R2 handshake clear", status, ex);
    end

    // R10 / R11 / R4 / R5 transmit-end
    do_reset(); tx_en = 1; cyc();
    dma_wr = 1; cyc(); dma_wr = 0;
    chk("R5 dma_wr clears tdre/tend", {status[7], status[2]}, 8'h00);
    wr(8'h06);
    chk("R4 read-only bits ignore write", status[2:0], 3'b000);
    rx(8'h00, 0, 1);
    chk("R12 mpb captured", {7'b0, status[1]}, 8'h01);
    wr(8'h00);
    chk("R4 mpb unaffected by write", {7'b0, status[1]}, 8'h01);
    dma_rd = 1; cyc(); dma_rd = 0;
    rx(8'h00, 0, 0);
    chk("R12 mpb follows 0", {7'b0, status[1]}, 8'h00);
    dma_rd = 1; cyc(); dma_rd = 0;
    for (int g = 0; g < 2; g++) begin
      int n;
      n = g ? 2 : 5;
      tx_load = 1; cyc(); tx_load = 0;
      chk("R5 load sets tdre", {7'b0, status[7]}, 8'h01);
      guard_mode = g[0];
      char_sent = 1; cyc(); char_sent = 0;
      for (int k = 1; k <= n; k++) begin
        cyc();
        half_tick = 1; cyc(); half_tick = 0;
        chk("R10 delay count", {7'b0, tx_end}, {7'b0, k == n});
      end
      dma_wr = 1; cyc(); dma_wr = 0;
    end
    guard_mode = 0;
    char_sent = 1; cyc(); char_sent = 0;
    tick_n(6);
    chk("R10 no set with tdre 0", {7'b0, tx_end}, 8'h00);
    tx_load = 1; cyc(); tx_load = 0;
    err_low = 1; cyc(); err_low = 0;
    char_sent = 1; cyc(); char_sent = 0;
    tick_n(6);
    chk("R10 no set with ers 1", {7'b0, tx_end}, 8'h00);
    tx_en = 0; cyc(); cyc();
    chk("R9 ers kept with tx_en 0", {7'b0, status[4]}, 8'h01);
    chk("R11 tend blocked by ers", {7'b0, tx_end}, 8'h00);
    rd(rv);
    wr(8'hEF);
    chk("R4 mpbt written 1", {7'b0, status[0]}, 8'h01);
    chk("R9 ers cleared by handshake", {7'b0, status[4]}, 8'h00);
    cyc();
    chk("R11 tend set with tx_en 0", {7'b0, tx_end}, 8'h01);
    tx_en = 1; cyc();
    rd(rv);
    wr(8'h7E);
    chk("R11 tend clears with tdre", {6'b0, status[7], status[2]}, 8'h00);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule